// File: doc/BRIEF.md
# Static Memory Bus Controller

The controller connects a simple internal request/acknowledge port to an external asynchronous SRAM or ROM bus. The bus has four chip-select banks. Each bank owns one 16 MiB window of the internal address space. Each bank also has a 4-bit attribute field and a 32-bit timing word, both supplied as static configuration inputs. The attribute field selects:

- an 8-bit or 16-bit data path,
- byte-based or half-word-based external addressing,
- whether the external wait input is honoured,
- whether the two byte-lane strobes are driven.

The timing word sets the length of each phase of an access. The phases run in this order:

1. Address set-up before chip select.
2. Chip-select set-up before the strobe.
3. The strobe (access) phase.
4. Chip-select hold after the strobe.
5. Address hold after chip select.

A requester raises `req` with address, direction, write data and byte enables. It holds them until `ack` pulses. The controller latches the request, runs the programmed phase sequence on the external pins and captures read data at the end of the strobe. It then acknowledges. The data bus is presented as separate output, output-enable and input vectors, for a pad ring to combine. An optional page mode shortens the strobe phase when an access falls in the same page as the previous windowed access to the same bank.

Top module: `sram_bus_ctrl`

## Requirements
- R1: An address whose bits [31:24] equal 4, 5, 6 or 7 targets bank 0, 1, 2 or 3 respectively. During the access, only that bank's active-low chip select `mem_cs_n[n]` goes low.
- R2: Timing word fields are: address set-up [3:0], chip-select set-up [7:4], access [12:8], chip-select hold [19:16], address hold [23:20], page access [27:24], page-mode enable [31]. Chip select is low for set-up + access + hold cycles. The strobe lies strictly inside the chip-select window. `ack` follows the sum of all five phases by one cycle.
- R3: An access count of zero gives a one-cycle strobe. A zero in any other phase count removes that phase entirely.
- R4: A read holds `mem_oe_n` low for the access phase while `mem_we_n` stays high. The value on `mem_dq_i` in the last access cycle is returned on `rdata`. An 8-bit bank returns the low byte with the upper byte zero.
- R5: A write holds `mem_we_n` low for the access phase. It drives `mem_dq_oe` while chip select is low: both lanes for a 16-bit bank, lane 0 only for an 8-bit bank. `mem_dq_o` carries the write data (low byte only for an 8-bit bank).
- R6: Attribute field n is `cfg_attr[4n+3:4n]`. Its bit 0 selects a 16-bit bank and its bit 1 selects byte addressing. For a 16-bit bank without byte addressing, `mem_addr` is request address bits [16:1]. Otherwise it is bits [15:0].
- R7: With attribute bit 2 set, each access-phase cycle in which `mem_wait_n` is low extends the access phase by one cycle. With bit 2 clear, `mem_wait_n` has no effect.
- R8: With attribute bit 3 set, `mem_lb_n` follows `req_be[0]` and `mem_ub_n` follows `req_be[1]` (16-bit banks only) while chip select is low. With bit 3 clear, both stay high.
- R9: With page mode set in a bank's timing word, an access uses the page access count instead of the access count when two conditions hold. The previous windowed access must have hit the same bank, and `mem_addr` bits above bit 1 must be equal for both accesses.
- R10: `ack` is high for exactly one cycle per request. A request outside all four windows acknowledges in the next cycle. It returns zero and leaves every external strobe and chip select idle.
- R11: While reset is high, all chip selects, strobes and lane strobes are high, `mem_dq_oe` is zero and `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_attr | input | 4*NBANK | Per-bank attribute nibbles |
| cfg_timing | input | 32*NBANK | Per-bank timing words |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Internal byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 low lane) |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |
| mem_cs_n | output | NBANK | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lb_n | output | 1 | Active-low lower-lane strobe |
| mem_ub_n | output | 1 | Active-low upper-lane strobe |
| mem_addr | output | EXT_AW | External address |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe | output | 2 | Per-lane output enable |
| mem_dq_i | input | 16 | Data bus input value |
| mem_wait_n | input | 1 | Active-low external wait |

## Verification
Two functions can meet in the same access-phase cycle: the wait stretch and the read-data capture. If the capture fired on the counter alone, a wait asserted in the final counted cycle would latch data before the device was ready.

The bench holds `mem_wait_n` low for the first three strobe cycles of a read, driven from a memory model that returns a known word only while the read strobe is low. It judges the overlap by the strobe length and the returned word together. It then repeats the same stimulus with wait disabled, expecting the unstretched length.

A second overlap pairs the page-hit decision with a missed-window request, which must not disturb the remembered page.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int ATTR_W = 4;
    localparam int TIM_W  = 32;
    localparam int DW     = 16;

    // Attribute nibble: bit3 lanes, bit2 wait, bit1 byte addressing, bit0 wide
    typedef struct packed {
        logic lane_en;
        logic wait_en;
        logic byte_addr;
        logic wide;
    } attr_t;

    typedef struct packed {
        logic       page_en;   // [31]
        logic [2:0] rsv_hi;    // [30:28]
        logic [3:0] t_page;    // [27:24]
        logic [3:0] t_ahold;   // [23:20]
        logic [3:0] t_chold;   // [19:16]
        logic [2:0] rsv_mid;   // [15:13]
        logic [4:0] t_acc;     // [12:8]
        logic [3:0] t_csu;     // [7:4]
        logic [3:0] t_asu;     // [3:0]
    } timing_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ASU  = 3'd1,
        PH_CSU  = 3'd2,
        PH_ACC  = 3'd3,
        PH_CHD  = 3'd4,
        PH_AHD  = 3'd5,
        PH_ACK  = 3'd6
    } phase_e;

    typedef struct packed {
        logic [3:0] asu;
        logic [3:0] csu;
        logic [4:0] acc;
        logic [3:0] chd;
        logic [3:0] ahd;
    } lens_t;

    function automatic lens_t make_lens(timing_t t, logic page_hit);
        lens_t l;
        l.asu = t.t_asu;
        l.csu = t.t_csu;
        l.acc = page_hit ? {1'b0, t.t_page} : t.t_acc;
        if (l.acc == 5'd0) l.acc = 5'd1;
        l.chd = t.t_chold;
        l.ahd = t.t_ahold;
        return l;
    endfunction

    function automatic logic [4:0] len_of(phase_e p, lens_t l);
        logic [4:0] n;
        case (p)
            PH_ASU:  n = {1'b0, l.asu};
            PH_CSU:  n = {1'b0, l.csu};
            PH_ACC:  n = l.acc;
            PH_CHD:  n = {1'b0, l.chd};
            PH_AHD:  n = {1'b0, l.ahd};
            default: n = 5'd1;
        endcase
        return n;
    endfunction

    // First phase at or after 'from' that has a nonzero length.
    function automatic phase_e first_live(phase_e from, lens_t l);
        phase_e p;
        if (from <= PH_ASU && l.asu != 4'd0)      p = PH_ASU;
        else if (from <= PH_CSU && l.csu != 4'd0) p = PH_CSU;
        else if (from <= PH_ACC)                  p = PH_ACC;
        else if (from <= PH_CHD && l.chd != 4'd0) p = PH_CHD;
        else if (from <= PH_AHD && l.ahd != 4'd0) p = PH_AHD;
        else                                      p = PH_ACK;
        return p;
    endfunction

endpackage

// File: rtl/smc_decode.sv
module smc_decode #(
    parameter int          NBANK    = 4,
    parameter logic [31:0] WIN_BASE = 32'h0400_0000,
    parameter int          WIN_LOG2 = 24,
    localparam int         BW       = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int         TW       = 32 - WIN_LOG2
) (
    input  logic [31:0]   addr,
    output logic          hit,
    output logic [BW-1:0] bank
);
    localparam logic [TW-1:0] TOP = WIN_BASE[31:WIN_LOG2];

    logic [NBANK-1:0] hit_vec;

    for (genvar n = 0; n < NBANK; n++) begin : g_win
        assign hit_vec[n] = (addr[31:WIN_LOG2] == TOP + TW'(n));
    end

    always_comb begin
        bank = '0;
        for (int n = 0; n < NBANK; n++) begin
            if (hit_vec[n]) bank = BW'(n);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go_hit,
    input  logic   go_miss,
    input  logic   stall,
    input  lens_t  lens,
    output phase_e phase,
    output logic   last_acc
);
    logic [4:0] cnt, cnt_n;
    phase_e     phase_n, nxt;

    always_comb begin
        phase_n = phase;
        cnt_n   = cnt;
        nxt     = first_live(phase_e'(phase + 3'd1), lens);
        case (phase)
            PH_IDLE: begin
                if (go_hit) begin
                    phase_n = first_live(PH_ASU, lens);
                    cnt_n   = len_of(phase_n, lens) - 5'd1;
                end else if (go_miss) begin
                    phase_n = PH_ACK;
                end
            end
            PH_ACK: phase_n = PH_IDLE;
            default: begin
                if (!stall) begin
                    if (cnt == 5'd0) begin
                        phase_n = nxt;
                        cnt_n   = len_of(nxt, lens) - 5'd1;
                    end else begin
                        cnt_n = cnt - 5'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_n;
            cnt   <= cnt_n;
        end
    end

    assign last_acc = (phase == PH_ACC) && (cnt == 5'd0) && !stall;
endmodule

// File: rtl/smc_pins.sv
module smc_pins
    import smc_pkg::*;
#(
    parameter int  NBANK = 4,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  phase_e           phase,
    input  logic             is_wr,
    input  attr_t            attr,
    input  logic [1:0]       be,
    input  logic [BW-1:0]    bank,
    output logic [NBANK-1:0] cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             lb_n,
    output logic             ub_n,
    output logic [1:0]       dq_oe
);
    logic cs_act, strobe;

    assign cs_act = (phase == PH_CSU) || (phase == PH_ACC) || (phase == PH_CHD);
    assign strobe = (phase == PH_ACC);

    for (genvar n = 0; n < NBANK; n++) begin : g_cs
        assign cs_n[n] = !(cs_act && (bank == BW'(n)));
    end

    assign oe_n  = !(strobe && !is_wr);
    assign we_n  = !(strobe && is_wr);
    assign lb_n  = !(cs_act && attr.lane_en && be[0]);
    assign ub_n  = !(cs_act && attr.lane_en && attr.wide && be[1]);
    assign dq_oe = (cs_act && is_wr) ? {attr.wide, 1'b1} : 2'b00;
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import smc_pkg::*;
#(
    parameter int          NBANK    = 4,
    parameter int          EXT_AW   = 16,
    parameter logic [31:0] WIN_BASE = 32'h0400_0000,
    parameter int          WIN_LOG2 = 24,
    parameter int          PAGE_W   = 2,
    localparam int         BW       = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int         TAG_W    = EXT_AW - PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NBANK*4-1:0]    cfg_attr,
    input  logic [NBANK*32-1:0]   cfg_timing,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [31:0]           req_addr,
    input  logic [15:0]           req_wdata,
    input  logic [1:0]            req_be,
    output logic                  ack,
    output logic [15:0]           rdata,
    output logic [NBANK-1:0]      mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic                  mem_lb_n,
    output logic                  mem_ub_n,
    output logic [EXT_AW-1:0]     mem_addr,
    output logic [15:0]           mem_dq_o,
    output logic [1:0]            mem_dq_oe,
    input  logic [15:0]           mem_dq_i,
    input  logic                  mem_wait_n
);
    logic          hit;
    logic [BW-1:0] bank_now, bank_q;
    attr_t         attr_now, attr_q;
    timing_t       tim_now;
    lens_t         lens_now, lens_q, lens_use;
    phase_e        phase;
    logic          last_acc, stall, go_hit, go_miss, page_hit;
    logic [EXT_AW-1:0] ext_now;
    logic [EXT_AW:0]   byte_lo;
    logic          we_q;
    logic [1:0]    be_q;
    logic [15:0]   wdata_q;
    logic          last_v;
    logic [BW-1:0] last_bank;
    logic [TAG_W-1:0] last_tag;
    logic          unused_bits;

    assign unused_bits = ^req_addr[WIN_LOG2-1:EXT_AW+1] ^ tim_now.rsv_hi[0];

    smc_decode #(.NBANK(NBANK), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) dec_i (
        .addr (req_addr),
        .hit  (hit),
        .bank (bank_now)
    );

    assign attr_now = attr_t'(cfg_attr[bank_now*ATTR_W +: ATTR_W]);
    assign tim_now  = timing_t'(cfg_timing[bank_now*TIM_W +: TIM_W]);
    assign byte_lo  = req_addr[EXT_AW:0];
    assign ext_now  = (attr_now.wide && !attr_now.byte_addr) ? byte_lo[EXT_AW:1]
                                                             : byte_lo[EXT_AW-1:0];
    assign page_hit = tim_now.page_en && last_v && (last_bank == bank_now)
                      && (last_tag == ext_now[EXT_AW-1:PAGE_W]);
    assign lens_now = make_lens(tim_now, page_hit);

    assign go_hit   = (phase == PH_IDLE) && req && hit;
    assign go_miss  = (phase == PH_IDLE) && req && !hit;
    assign lens_use = (phase == PH_IDLE) ? lens_now : lens_q;
    assign stall    = (phase == PH_ACC) && attr_q.wait_en && !mem_wait_n;

    smc_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .go_hit   (go_hit),
        .go_miss  (go_miss),
        .stall    (stall),
        .lens     (lens_use),
        .phase    (phase),
        .last_acc (last_acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q    <= '0;
            attr_q    <= '0;
            lens_q    <= '0;
            we_q      <= 1'b0;
            be_q      <= '0;
            wdata_q   <= '0;
            mem_addr  <= '0;
            rdata     <= '0;
            last_v    <= 1'b0;
            last_bank <= '0;
            last_tag  <= '0;
        end else begin
            if (go_hit) begin
                bank_q    <= bank_now;
                attr_q    <= attr_now;
                lens_q    <= lens_now;
                we_q      <= req_we;
                be_q      <= req_be;
                wdata_q   <= req_wdata;
                mem_addr  <= ext_now;
                last_v    <= 1'b1;
                last_bank <= bank_now;
                last_tag  <= ext_now[EXT_AW-1:PAGE_W];
            end
            if (go_miss) begin
                rdata <= '0;
            end else if (last_acc && !we_q) begin
                rdata <= attr_q.wide ? mem_dq_i : {8'h00, mem_dq_i[7:0]};
            end
        end
    end

    smc_pins #(.NBANK(NBANK)) pins_i (
        .phase (phase),
        .is_wr (we_q),
        .attr  (attr_q),
        .be    (be_q),
        .bank  (bank_q),
        .cs_n  (mem_cs_n),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .lb_n  (mem_lb_n),
        .ub_n  (mem_ub_n),
        .dq_oe (mem_dq_oe)
    );

    assign mem_dq_o = attr_q.wide ? wdata_q : {8'h00, wdata_q[7:0]};
    assign ack      = (phase == PH_ACK);
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic [NBANK-1:0] mem_cs_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic             mem_lb_n,
    input logic             mem_ub_n,
    input logic [1:0]       mem_dq_oe
);
    logic cs_any;
    assign cs_any = (mem_cs_n != {NBANK{1'b1}});

    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> cs_any);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_wr_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe != 2'b00) |-> (mem_oe_n && cs_any));

    assert_lane_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_lb_n || !mem_ub_n) |-> cs_any);

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!cs_any && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !ack));
endmodule

bind sram_bus_ctrl smc_checker #(.NBANK(NBANK)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_bus_ctrl_tb_top.sv
module sram_bus_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB*4-1:0]  cfg_attr = '0;
    logic [NB*32-1:0] cfg_timing = '0;
    logic          req = 1'b0, req_we = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_be = '0;
    logic          ack;
    logic [15:0]   rdata;
    logic [NB-1:0] mem_cs_n;
    logic          mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0]   mem_addr;
    logic [15:0]   mem_dq_o;
    logic [1:0]    mem_dq_oe;
    logic [15:0]   mem_dq_i;
    logic          mem_wait_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_attr(cfg_attr), .cfg_timing(cfg_timing),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .ack(ack), .rdata(rdata), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_wait_n(mem_wait_n)
    );

    // memory model: returns the word only while the read strobe is low
    logic [15:0] cur_rd = '0;
    int          cur_wait_k = 0;
    assign mem_dq_i = !mem_oe_n ? cur_rd : 16'hDEAD;

    int n_checks = 0, n_err = 0;
    bit done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        string tag;
        int lat, bank, cs, oe, we, lb, ub, addr, rd, wd;
        bit is_wr;
    } exp_t;
    exp_t q[$];

    // bench copy of configuration
    int a_b[NB];
    int asu_b[NB], csu_b[NB], acc_b[NB], chd_b[NB], ahd_b[NB], pg_b[NB], pen_b[NB];
    bit last_v = 0;
    int last_bank = 0, last_page = 0;

    task automatic set_bank(int b, int attr, int asu, int csu, int acc, int chd,
                            int ahd, int pg, int pen);
        a_b[b] = attr; asu_b[b] = asu; csu_b[b] = csu; acc_b[b] = acc;
        chd_b[b] = chd; ahd_b[b] = ahd; pg_b[b] = pg; pen_b[b] = pen;
        cfg_attr[b*4 +: 4] = 4'(attr);
        cfg_timing[b*32 +: 32] = {1'(pen), 3'b0, 4'(pg), 4'(ahd), 4'(chd), 3'b0,
                                  5'(acc), 4'(csu), 4'(asu)};
    endtask

    task automatic access(string tag, logic [31:0] a, logic w, logic [15:0] wd,
                          logic [1:0] be, logic [15:0] rd, int wk);
        exp_t e;
        int b, acc, cs, ext;
        bit wide, ba, wen, ln, ph;
        e.tag = tag; e.is_wr = w;
        if (a[31:24] >= 8'd4 && a[31:24] <= 8'd7) begin
            b = int'(a[31:24]) - 4;
            wide = a_b[b][0]; ba = a_b[b][1]; wen = a_b[b][2]; ln = a_b[b][3];
            ext = (wide && !ba) ? int'(a[16:1]) : int'(a[15:0]);
            ph = pen_b[b] != 0 && last_v && last_bank == b && last_page == (ext >> 2);
            last_v = 1; last_bank = b; last_page = ext >> 2;
            acc = ph ? pg_b[b] : acc_b[b];
            if (acc == 0) acc = 1;
            if (wen && !w) acc = acc + wk;
            cs = csu_b[b] + acc + chd_b[b];
            e.lat = asu_b[b] + cs + ahd_b[b] + 1;
            e.bank = b; e.cs = cs;
            e.oe = w ? 0 : acc; e.we = w ? acc : 0;
            e.lb = (ln && be[0]) ? cs : 0;
            e.ub = (ln && wide && be[1]) ? cs : 0;
            e.addr = ext;
            e.rd = wide ? int'(rd) : int'(rd[7:0]);
            e.wd = w ? (wide ? int'(wd) : int'(wd[7:0])) : 0;
        end else begin
            e.lat = 1; e.bank = -1; e.cs = 0; e.oe = 0; e.we = 0; e.lb = 0;
            e.ub = 0; e.addr = -1; e.rd = 0; e.wd = 0; e.is_wr = 0;
        end
        q.push_back(e);
        @(posedge clk); #1;
        cur_rd = rd; cur_wait_k = wk;
        req_addr = a; req_we = w; req_wdata = wd; req_be = be; req = 1'b1;
        forever begin
            @(posedge clk); #1;
            if (ack) break;
        end
        @(posedge clk); #1;
        req = 1'b0;
    endtask

    // monitor / scoreboard
    int o_lat, o_bank, o_cs, o_oe, o_we, o_lb, o_ub, o_addr, o_wd;
    task automatic clear_obs();
        o_lat = 0; o_bank = -1; o_cs = 0; o_oe = 0; o_we = 0; o_lb = 0;
        o_ub = 0; o_addr = -1; o_wd = 0;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            clear_obs();
            mem_wait_n = 1'b1;
        end else if (ack) begin
            if (q.size() == 0) begin
                chk("R10", "unexpected ack", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, "/R2"}, "latency", o_lat, e.lat);
                chk({e.tag, "/R1"}, "bank", o_bank, e.bank);
                chk({e.tag, "/R2"}, "cs cycles", o_cs, e.cs);
                chk({e.tag, "/R4"}, "oe cycles", o_oe, e.oe);
                chk({e.tag, "/R5"}, "we cycles", o_we, e.we);
                chk({e.tag, "/R8"}, "lb cycles", o_lb, e.lb);
                chk({e.tag, "/R8"}, "ub cycles", o_ub, e.ub);
                if (e.bank >= 0) chk({e.tag, "/R6"}, "ext addr", o_addr, e.addr);
                if (e.is_wr) chk({e.tag, "/R5"}, "write data", o_wd, e.wd);
                else         chk({e.tag, "/R4"}, "rdata", int'(rdata), e.rd);
            end
            clear_obs();
            mem_wait_n = 1'b1;
        end else begin
            if (req) o_lat++;
            for (int i = 0; i < NB; i++) if (!mem_cs_n[i]) o_bank = i;
            if (mem_cs_n != '1) o_cs++;
            if (!mem_lb_n) o_lb++;
            if (!mem_ub_n) o_ub++;
            if (!mem_we_n) begin
                o_we++;
                o_addr = int'(mem_addr);
                o_wd = int'({mem_dq_oe[1] ? mem_dq_o[15:8] : 8'h00,
                             mem_dq_oe[0] ? mem_dq_o[7:0]  : 8'h00});
            end
            if (!mem_oe_n) begin
                o_oe++;
                o_addr = int'(mem_addr);
                mem_wait_n = (o_oe <= cur_wait_k) ? 1'b0 : 1'b1;
            end else begin
                mem_wait_n = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        set_bank(0, 4'h0, 1, 2, 3, 1, 2, 0, 0);
        set_bank(1, 4'h9, 0, 0, 0, 0, 0, 0, 0);
        set_bank(2, 4'h5, 2, 1, 2, 2, 1, 0, 0);
        set_bank(3, 4'h3, 1, 1, 4, 1, 1, 1, 1);
        repeat (3) @(posedge clk);
        #2;
        // R11: idle pins during reset
        chk("R11", "cs_n", int'(mem_cs_n), 15);
        chk("R11", "oe_n/we_n", int'({mem_oe_n, mem_we_n}), 3);
        chk("R11", "lanes", int'({mem_lb_n, mem_ub_n}), 3);
        chk("R11", "dq_oe", int'(mem_dq_oe), 0);
        chk("R11", "ack", int'(ack), 0);
        @(posedge clk); #1; rst = 1'b0;

        // R1 R4 R6: 8-bit bank read, low byte only
        access("R4", 32'h0400_0123, 1'b0, 16'h0, 2'b11, 16'hA55A, 0);
        // R5: 8-bit bank write drives lane 0 only
        access("R5", 32'h0400_0124, 1'b1, 16'hBEEF, 2'b11, 16'h0, 0);
        // R3 R8: all-zero timing, lane strobes follow byte enables
        access("R3", 32'h0500_0010, 1'b1, 16'h1357, 2'b10, 16'h0, 0);
        access("R3", 32'h0500_0011, 1'b0, 16'h0, 2'b01, 16'h1234, 0);
        // R7: wait stretches the strobe; capture after the stretch
        access("R7", 32'h0600_0246, 1'b0, 16'h0, 2'b11, 16'hC0DE, 3);
        set_bank(2, 4'h1, 2, 1, 2, 2, 1, 0, 0);
        // R7: wait disabled, same stimulus has no effect
        access("R7", 32'h0600_0246, 1'b0, 16'h0, 2'b11, 16'h4321, 3);
        // R9: page mode, hit then page change
        access("R9", 32'h0700_0100, 1'b0, 16'h0, 2'b11, 16'h1111, 0);
        access("R9", 32'h0700_0102, 1'b0, 16'h0, 2'b11, 16'h2222, 0);
        access("R9", 32'h0700_0108, 1'b0, 16'h0, 2'b11, 16'h3333, 0);
        // R10: misses outside all windows
        access("R10", 32'h0800_0000, 1'b0, 16'h0, 2'b11, 16'hFFFF, 0);
        access("R10", 32'h0000_1000, 1'b1, 16'h5555, 2'b11, 16'h0, 0);
        // R9: a miss between must not break the page hit
        access("R9", 32'h0700_010A, 1'b1, 16'h6789, 2'b11, 16'h0, 0);
        access("R6", 32'h0500_0100, 1'b1, 16'hA1B2, 2'b11, 16'h0, 0);
        repeat (4) @(posedge clk);
        chk("R10", "pending items", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule